// File: doc/BRIEF.md
# Scanline Interrupt Sequencer

This block keeps the vertical position of a raster display as a line number and drives the interrupt lines of four processors from it. One pulse on `line_start` marks the start of each new line. The frame has a fixed number of lines. Every event is decoded on the line that the counter is about to enter, so an output changes in the same clock edge that loads the new line number.

The main processor gets a level interrupt when vertical blanking begins. The second processor gets a single-cycle pulse when blanking ends. The microcontroller sees a non-maskable interrupt level that is high from the end of blanking until the next blanking start. The sound processor gets a tempo request each time bit 6 of the line number goes from 0 to 1. The same end-of-blanking event flips the page select of a double-buffered sprite store. The main and sound interrupts stay high until the matching acknowledge input pulses.

Top module: `scan_irq_seq`

## Requirements
- R1: Each cycle with `line_start` high advances `line_num` by one. From 263 it goes back to 0, so the frame is 264 lines long.
- R2: On entering line 240, `main_irq` goes high. It stays high until a cycle with `main_ack` high, after which it is low.
- R3: On entering line 16, `sub_irq` is high for exactly one cycle. At all other times it is low.
- R4: On entering line 16, `mcu_nmi` goes high. On entering line 240, it goes low. It does not change at any other time.
- R5: On entering line 16, `sprite_page` inverts. It does not change at any other time.
- R6: On entering lines 64 and 192, `sound_irq` goes high. These are the two lines where bit 6 of the line number rises. It stays high until a cycle with `sound_ack` high.
- R7: If an event that sets `main_irq` or `sound_irq` falls in the same cycle as that line's acknowledge, the event wins and the interrupt stays high.
- R8: While `rst_n` is low, `line_num` is 0, all four interrupt outputs are low and `sprite_page` is 0.
- R9: In cycles with `line_start` low, `line_num`, `sub_irq`, `mcu_nmi` and `sprite_page` keep their values. `main_irq` and `sound_irq` change only through their acknowledge inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| main_ack | input | 1 | Acknowledge pulse for `main_irq` |
| sound_ack | input | 1 | Acknowledge pulse for `sound_irq` |
| line_num | output | 9 | Current line number |
| main_irq | output | 1 | Main processor interrupt level |
| sub_irq | output | 1 | Second processor interrupt pulse |
| mcu_nmi | output | 1 | Microcontroller non-maskable interrupt level |
| sound_irq | output | 1 | Sound processor tempo request level |
| sprite_page | output | 1 | Sprite buffer page select |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as the event that sets the same interrupt. Line events fire only once or twice per frame, so the stimulus has to count line pulses to the exact line, hold the acknowledge high together with the line pulse that enters line 240, and do the same for line 192. The bench also runs the counter through more than one full frame. This covers the wrap, shows the sprite page flipping twice, and shows that the tempo edge does not fire on the 127-to-128 or 263-to-0 transitions. Idle cycles between line pulses show that nothing moves without `line_start`.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
   typedef struct packed {
      logic blank_on;
      logic blank_off;
      logic tempo;
   } line_evt_t;

   localparam int IRQ_MAIN  = 0;
   localparam int IRQ_SOUND = 1;
   localparam int IRQ_HELD  = 2;
endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
   parameter int LINES  = 264,
   parameter int LINE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [LINE_W-1:0] line_q,
   output logic [LINE_W-1:0] line_d
);
   localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

   always_comb begin
      if (line_q == LAST) line_d = '0;
      else                line_d = line_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   line_q <= '0;
      else if (adv) line_q <= line_d;
   end
endmodule

// File: rtl/scan_evt_dec.sv
module scan_evt_dec
   import scan_seq_pkg::*;
#(
   parameter int LINE_W    = 9,
   parameter int BLANK_ON  = 240,
   parameter int BLANK_OFF = 16,
   parameter int TEMPO_BIT = 6
) (
   input  logic              adv,
   input  logic [LINE_W-1:0] line_q,
   input  logic [LINE_W-1:0] line_d,
   output line_evt_t         evt
);
   always_comb begin
      evt.blank_on  = adv && (line_d == LINE_W'(BLANK_ON));
      evt.blank_off = adv && (line_d == LINE_W'(BLANK_OFF));
      evt.tempo     = adv && line_d[TEMPO_BIT] && !line_q[TEMPO_BIT];
   end
endmodule

// File: rtl/irq_hold.sv
module irq_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)   irq <= 1'b0;
      else if (set) irq <= 1'b1;
      else if (ack) irq <= 1'b0;
   end
endmodule

// File: rtl/scan_irq_seq.sv
module scan_irq_seq
   import scan_seq_pkg::*;
#(
   parameter int LINES     = 264,
   parameter int BLANK_ON  = 240,
   parameter int BLANK_OFF = 16,
   parameter int TEMPO_BIT = 6,
   parameter int LINE_W    = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              main_ack,
   input  logic              sound_ack,
   output logic [LINE_W-1:0] line_num,
   output logic              main_irq,
   output logic              sub_irq,
   output logic              mcu_nmi,
   output logic              sound_irq,
   output logic              sprite_page
);
   generate
      if (LINES < 2)                $error("LINES must be at least 2");
      if (BLANK_ON >= LINES)        $error("BLANK_ON outside the frame");
      if (BLANK_OFF >= LINES)       $error("BLANK_OFF outside the frame");
      if (BLANK_ON == BLANK_OFF)    $error("blanking edges must differ");
      if (TEMPO_BIT >= LINE_W)      $error("TEMPO_BIT beyond line width");
      if ((1 << LINE_W) < LINES)    $error("LINE_W too narrow");
   endgenerate

   logic [LINE_W-1:0] line_d;
   line_evt_t         evt;
   logic [IRQ_HELD-1:0] held_set, held_ack, held_irq;

   scan_line_ctr #(.LINES(LINES), .LINE_W(LINE_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .adv(line_start),
      .line_q(line_num), .line_d(line_d)
   );

   scan_evt_dec #(
      .LINE_W(LINE_W), .BLANK_ON(BLANK_ON),
      .BLANK_OFF(BLANK_OFF), .TEMPO_BIT(TEMPO_BIT)
   ) u_dec (
      .adv(line_start), .line_q(line_num), .line_d(line_d), .evt(evt)
   );

   assign held_set[IRQ_MAIN]  = evt.blank_on;
   assign held_ack[IRQ_MAIN]  = main_ack;
   assign held_set[IRQ_SOUND] = evt.tempo;
   assign held_ack[IRQ_SOUND] = sound_ack;

   for (genvar g = 0; g < IRQ_HELD; g++) begin : g_hold
      irq_hold u_hold (
         .clk(clk), .rst_n(rst_n),
         .set(held_set[g]), .ack(held_ack[g]), .irq(held_irq[g])
      );
   end

   assign main_irq  = held_irq[IRQ_MAIN];
   assign sound_irq = held_irq[IRQ_SOUND];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub_irq     <= 1'b0;
         mcu_nmi     <= 1'b0;
         sprite_page <= 1'b0;
      end else begin
         sub_irq <= evt.blank_off;
         if (evt.blank_off)     mcu_nmi <= 1'b1;
         else if (evt.blank_on) mcu_nmi <= 1'b0;
         if (evt.blank_off) sprite_page <= ~sprite_page;
      end
   end
endmodule

// File: rtl/scan_irq_seq_chk.sv
module scan_irq_seq_chk #(
   parameter int LINES     = 264,
   parameter int BLANK_ON  = 240,
   parameter int BLANK_OFF = 16,
   parameter int LINE_W    = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_start,
   input logic              main_ack,
   input logic              sound_ack,
   input logic [LINE_W-1:0] line_num,
   input logic              main_irq,
   input logic              sub_irq,
   input logic              mcu_nmi,
   input logic              sound_irq,
   input logic              sprite_page
);
   assert_line_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      line_num < LINE_W'(LINES));
   assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && line_num == LINE_W'(LINES - 1) |=> line_num == '0);
   assert_main_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && line_num == LINE_W'(BLANK_ON - 1) |=> main_irq);
   assert_sub_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sub_irq |=> !sub_irq);
   assert_nmi_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mcu_nmi) |-> line_num == LINE_W'(BLANK_OFF));
   assert_page_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sprite_page) |-> line_num == LINE_W'(BLANK_OFF) && sub_irq);
   assert_main_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(main_irq) |-> $past(main_ack));
   assert_sound_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sound_irq) |-> $past(sound_ack));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(line_num) && !sub_irq);
endmodule

bind scan_irq_seq scan_irq_seq_chk #(
   .LINES(LINES), .BLANK_ON(BLANK_ON), .BLANK_OFF(BLANK_OFF), .LINE_W(LINE_W)
) i_chk (.*);

// File: tb/test_scan_irq_seq.sv
module test_scan_irq_seq;
   typedef struct {
      int    line;
      bit    main_i, sub_i, nmi, snd, page;
      string tag;
   } exp_t;

   logic clk = 0, rst_n = 0, line_start = 0, main_ack = 0, sound_ack = 0;
   logic [8:0] line_num;
   logic main_irq, sub_irq, mcu_nmi, sound_irq, sprite_page;
   int vectors = 0, errors = 0;
   exp_t q[$];
   exp_t m;
   bit   done = 0;

   always #5 clk = ~clk;

   scan_irq_seq i_scan_irq_seq (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .main_ack(main_ack), .sound_ack(sound_ack), .line_num(line_num),
      .main_irq(main_irq), .sub_irq(sub_irq), .mcu_nmi(mcu_nmi),
      .sound_irq(sound_irq), .sprite_page(sprite_page)
   );

   task automatic cyc(bit ls, bit ma, bit sa, string tag);
      int nl;
      bit ev_on, ev_off, ev_t;
      @(negedge clk);
      line_start = ls; main_ack = ma; sound_ack = sa;
      nl     = (m.line == 263) ? 0 : m.line + 1;
      ev_on  = ls && nl == 240;
      ev_off = ls && nl == 16;
      ev_t   = ls && nl[6] && !m.line[6];
      if (ls) m.line = nl;
      m.main_i = ev_on ? 1'b1 : (ma ? 1'b0 : m.main_i);
      m.snd    = ev_t  ? 1'b1 : (sa ? 1'b0 : m.snd);
      m.sub_i  = ev_off;
      if (ev_off) m.nmi = 1'b1; else if (ev_on) m.nmi = 1'b0;
      if (ev_off) m.page = ~m.page;
      m.tag = tag;
      q.push_back(m);
   endtask

   task automatic lines_to(int target, string tag);
      while (m.line != target) begin
         cyc(1, 0, 0, tag);
         cyc(0, 0, 0, "R9");
      end
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk); #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            vectors++;
            if (line_num != e.line[8:0] || main_irq != e.main_i ||
                sub_irq != e.sub_i || mcu_nmi != e.nmi ||
                sound_irq != e.snd || sprite_page != e.page) begin
               errors++;
               $display("FAIL %s: got line=%0d main=%b sub=%b nmi=%b snd=%b page=%b exp line=%0d main=%b sub=%b nmi=%b snd=%b page=%b",
                  e.tag, line_num, main_irq, sub_irq, mcu_nmi, sound_irq, sprite_page,
                  e.line, e.main_i, e.sub_i, e.nmi, e.snd, e.page);
            end
         end
      end
   end

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang exp finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : driver
      m = '{line: 0, main_i: 0, sub_i: 0, nmi: 0, snd: 0, page: 0, tag: "R8"};
      // R8: values held during reset
      rst_n = 0;
      cyc(1, 0, 0, "R8");
      m = '{line: 0, main_i: 0, sub_i: 0, nmi: 0, snd: 0, page: 0, tag: "R8"};
      q.delete();
      @(negedge clk); rst_n = 1; line_start = 0;
      cyc(0, 0, 0, "R8");
      // R1/R3/R4/R5: reach end of blanking
      lines_to(16, "R3");
      cyc(0, 0, 0, "R9");
      // R6: first tempo event, acknowledge later
      lines_to(64, "R6");
      cyc(0, 0, 1, "R6");
      lines_to(127, "R6");
      cyc(1, 0, 0, "R6");
      // R6: second tempo event, R7 with ack in same cycle
      lines_to(191, "R6");
      cyc(1, 0, 1, "R7");
      cyc(0, 0, 1, "R6");
      // R2/R7: ack coincides with entering blanking
      lines_to(239, "R2");
      cyc(1, 1, 0, "R7");
      cyc(0, 0, 0, "R2");
      cyc(0, 1, 0, "R2");
      // R1: wrap through 263 -> 0, second frame
      lines_to(263, "R1");
      cyc(1, 0, 0, "R1");
      lines_to(16, "R5");
      lines_to(240, "R4");
      cyc(0, 1, 1, "R2");
      lines_to(5, "R1");
      // R8: reset mid-frame
      @(negedge clk); rst_n = 0; line_start = 0;
      @(negedge clk); rst_n = 1;
      m = '{line: 0, main_i: 0, sub_i: 0, nmi: 0, snd: 0, page: 0, tag: "R8"};
      cyc(0, 0, 0, "R8");
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule